// File: doc/BRIEF.md
# Strobed BCD Digit Capture Unit

This block sits between a dual-slope integrating converter with a 3½-digit BCD output and a processor that polls it. The converter puts one 4-bit digit at a time on a shared bus and marks each digit with a strobe. There are three strobe wires. The most-significant-digit strobe has a wire of its own, and so does the tens strobe. The hundreds strobe and the units strobe share the third wire, so the block tells them apart by where they fall in the sequence. A raw end-of-conversion pulse opens each read cycle. The block widens that pulse into a flag that is long enough for a slow polling loop to catch.

All inputs are brought into the local clock domain. The block then follows the strobes in their fixed order and collects the four digits into a shadow word. When the last digit arrives, the whole 16-bit result is committed in a single step. The processor reads the result through one byte-wide port with a select line. Reading the high byte acknowledges the result. The most significant digit is a status nibble, and the block decodes it into the half digit, the polarity, overrange and underrange. It also forms the binary magnitude of the reading, from 0 to 1999.

Top module: `bdc_capture`

## Requirements
- R1: After reset, `eoc_seen` and `result_valid` are 0, `rd_data` is 0 for both byte selects, and all decoded outputs are 0.
- R2: An `eoc_in` pulse that is high for one clock holds `eoc_seen` high for exactly STRETCH_CYCLES clocks. A pulse that is high for L clocks holds it high for L+STRETCH_CYCLES-1 clocks.
- R3: After an end-of-conversion pulse, the digits are captured in this order. The digit present at the rising edge of `ds_msd_in` goes to result bits 15:12. The first rising edge on `ds_shared_in` goes to bits 11:8. The rising edge of `ds_mid_in` goes to bits 7:4. The second rising edge on `ds_shared_in` goes to bits 3:0.
- R4: A strobe edge that does not match the next expected digit has no effect. This covers any strobe that arrives before an end-of-conversion pulse, a repeated most-significant strobe, and a tens strobe that arrives before the hundreds.
- R5: A new end-of-conversion pulse throws away any digits already gathered and restarts at the most significant digit. The result word changes only when the fourth digit of a complete sequence is captured.
- R6: `result_valid` goes to 1 when the fourth digit is captured. It clears on a `rd_strobe` with `rd_port`=1 (high byte). A read with `rd_port`=0 (low byte) leaves it unchanged.
- R7: `rd_data` shows result bits 15:8 when `rd_port`=1 and bits 7:0 when `rd_port`=0.
- R8: The result bits decode as follows. Bit 15 drives `half_digit`. Bit 14 drives `positive` (1 means positive). Bit 13 drives `over_range`. Bit 12 drives `under_range`.
- R9: `magnitude` equals 1000×bit15 + 100×bits[11:8] + 10×bits[7:4] + bits[3:0]. With BCD digits this lies in the range 0 to 1999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc_in | input | 1 | Raw end-of-conversion pulse from the converter |
| digit_in | input | 4 | Multiplexed digit bus |
| ds_msd_in | input | 1 | Most-significant-digit strobe |
| ds_shared_in | input | 1 | Combined strobe line for the hundreds and units digits |
| ds_mid_in | input | 1 | Tens-digit strobe |
| rd_port | input | 1 | Byte select: 1 selects the high byte, 0 the low byte |
| rd_strobe | input | 1 | Single-cycle processor read pulse |
| eoc_seen | output | 1 | Stretched end-of-conversion flag |
| result_valid | output | 1 | A complete, unread result is held |
| rd_data | output | 8 | Selected byte of the result word |
| half_digit | output | 1 | Decoded half digit (counts as 1000) |
| positive | output | 1 | Decoded polarity, 1 means positive |
| over_range | output | 1 | Decoded overrange flag |
| under_range | output | 1 | Decoded underrange flag |
| magnitude | output | 11 | Binary magnitude of the reading |

## Verification
The hardest state to reach from the ports is a sequence that has been only partly gathered. Such a sequence is cut off by a fresh end-of-conversion pulse, or it receives strobes in an order the converter should never produce. Neither case shows up at the outputs until a later sequence either completes or fails to. To reach it, the stimulus interleaves real strobes with stray ones: a tens strobe before the hundreds, a repeated most-significant strobe, and strobes before any end-of-conversion pulse. It also aborts a half-finished sequence with a new pulse. After each of these it checks that the previously committed word and the valid flag stay untouched until a clean four-digit sequence finishes.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int DIGIT_W = 4;
  localparam int NDIGITS = 4;
  localparam int WORD_W  = DIGIT_W * NDIGITS;
  localparam int BYTE_W  = 8;
  localparam int MAG_W   = 11;

  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_MSD  = 3'd1,
    SEQ_HUN  = 3'd2,
    SEQ_TEN  = 3'd3,
    SEQ_UNI  = 3'd4
  } seq_t;

  // binary magnitude from the half digit and three BCD digits
  function automatic logic [MAG_W-1:0] bcd_mag(input logic half,
                                               input logic [DIGIT_W-1:0] hun,
                                               input logic [DIGIT_W-1:0] ten,
                                               input logic [DIGIT_W-1:0] uni);
    logic [MAG_W-1:0] acc;
    acc = half ? MAG_W'(1000) : '0;
    acc = acc + MAG_W'(hun) * MAG_W'(100);
    acc = acc + MAG_W'(ten) * MAG_W'(10);
    acc = acc + MAG_W'(uni);
    return acc;
  endfunction
endpackage

// File: rtl/bdc_sync.sv
module bdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES < 2) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES*W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[(STAGES-1)*W-1:0], d};
      end
      assign q = chain[STAGES*W-1 -: W];
    end
  endgenerate
endmodule

// File: rtl/bdc_eoc_stretch.sv
module bdc_eoc_stretch #(
  parameter int STRETCH_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_lvl,
  output logic eoc_rise,
  output logic eoc_flag
);
  localparam int CW = $clog2(STRETCH_CYCLES + 1);

  logic          eoc_prev;
  logic [CW-1:0] hold_cnt;

  assign eoc_rise = eoc_lvl & ~eoc_prev;
  assign eoc_flag = (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_prev <= 1'b0;
      hold_cnt <= '0;
    end else begin
      eoc_prev <= eoc_lvl;
      if (eoc_lvl)
        hold_cnt <= CW'(STRETCH_CYCLES);
      else if (hold_cnt != '0)
        hold_cnt <= hold_cnt - CW'(1);
    end
  end

  // width tracker for the flag, used by the assertion below
  logic [CW+1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_len <= '0;
    else if (!eoc_flag)          run_len <= '0;
    else if (run_len != '1)      run_len <= run_len + 1'b1;
  end

  AST_STRETCH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_flag) |-> (run_len >= (CW+2)'(STRETCH_CYCLES)));  // R2
  AST_FLAG_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_lvl |=> eoc_flag);  // R2
endmodule

// File: rtl/bdc_strobe_seq.sv
module bdc_strobe_seq
  import bdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eoc_rise,
  input  logic [2:0]         strb_lvl,   // {mid, shared, msd}
  input  logic [DIGIT_W-1:0] digit,
  output logic               commit,
  output logic [WORD_W-1:0]  commit_word
);
  localparam int L_MSD = 0;
  localparam int L_SHR = 1;
  localparam int L_MID = 2;

  logic [2:0] strb_prev;
  logic [2:0] strb_rise;

  genvar gi;
  generate
    for (gi = 0; gi < 3; gi++) begin : g_edge
      assign strb_rise[gi] = strb_lvl[gi] & ~strb_prev[gi];
    end
  endgenerate

  seq_t state_q, state_d;
  logic [DIGIT_W-1:0] sh_msd, sh_hun, sh_ten;

  // named capture events, one per digit slot
  logic [NDIGITS-1:0] cap;
  assign cap[3] = (state_q == SEQ_MSD) && strb_rise[L_MSD] && !eoc_rise;
  assign cap[2] = (state_q == SEQ_HUN) && strb_rise[L_SHR] && !eoc_rise;
  assign cap[1] = (state_q == SEQ_TEN) && strb_rise[L_MID] && !eoc_rise;
  assign cap[0] = (state_q == SEQ_UNI) && strb_rise[L_SHR] && !eoc_rise;

  assign commit      = cap[0];
  assign commit_word = {sh_msd, sh_hun, sh_ten, digit};

  always_comb begin
    state_d = state_q;
    if (eoc_rise) begin
      state_d = SEQ_MSD;
    end else begin
      case (state_q)
        SEQ_MSD: if (cap[3]) state_d = SEQ_HUN;
        SEQ_HUN: if (cap[2]) state_d = SEQ_TEN;
        SEQ_TEN: if (cap[1]) state_d = SEQ_UNI;
        SEQ_UNI: if (cap[0]) state_d = SEQ_IDLE;
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_prev <= '0;
      state_q   <= SEQ_IDLE;
      sh_msd    <= '0;
      sh_hun    <= '0;
      sh_ten    <= '0;
    end else begin
      strb_prev <= strb_lvl;
      state_q   <= state_d;
      if (cap[3]) sh_msd <= digit;
      if (cap[2]) sh_hun <= digit;
      if (cap[1]) sh_ten <= digit;
    end
  end

  AST_CAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap));  // R3
  AST_EOC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_rise |=> (state_q == SEQ_MSD));  // R5
  AST_IDLE_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && !eoc_rise) |=> (state_q == SEQ_IDLE));  // R4
endmodule

// File: rtl/bdc_result_port.sv
module bdc_result_port
  import bdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] commit_word,
  input  logic              rd_port,
  input  logic              rd_strobe,
  output logic              result_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              half_digit,
  output logic              positive,
  output logic              over_range,
  output logic              under_range,
  output logic [MAG_W-1:0]  magnitude
);
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic              hi_read;

  assign hi_read = rd_strobe & rd_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (commit) word_q <= commit_word;
      if (commit)       valid_q <= 1'b1;
      else if (hi_read) valid_q <= 1'b0;
    end
  end

  assign result_valid = valid_q;
  assign rd_data      = rd_port ? word_q[WORD_W-1 -: BYTE_W] : word_q[BYTE_W-1:0];
  assign half_digit   = word_q[15];
  assign positive     = word_q[14];
  assign over_range   = word_q[13];
  assign under_range  = word_q[12];
  assign magnitude    = bcd_mag(word_q[15], word_q[11:8], word_q[7:4], word_q[3:0]);

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> $past(commit));  // R5
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> valid_q);  // R6
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_read && !commit) |=> !valid_q);  // R6
  AST_LO_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_port && !commit) |=> $stable(valid_q));  // R6
endmodule

// File: rtl/bdc_capture.sv
module bdc_capture
  import bdc_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int STRETCH_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eoc_in,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic               ds_msd_in,
  input  logic               ds_shared_in,
  input  logic               ds_mid_in,
  input  logic               rd_port,
  input  logic               rd_strobe,
  output logic               eoc_seen,
  output logic               result_valid,
  output logic [BYTE_W-1:0]  rd_data,
  output logic               half_digit,
  output logic               positive,
  output logic               over_range,
  output logic               under_range,
  output logic [MAG_W-1:0]   magnitude
);
  localparam int BUNDLE_W = DIGIT_W + 4;

  logic [BUNDLE_W-1:0] raw_bundle, sync_bundle;
  logic                eoc_lvl, eoc_rise;
  logic [2:0]          strb_lvl;
  logic [DIGIT_W-1:0]  digit_s;
  logic                commit;
  logic [WORD_W-1:0]   commit_word;

  assign raw_bundle = {eoc_in, ds_mid_in, ds_shared_in, ds_msd_in, digit_in};

  bdc_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bundle), .q(sync_bundle)
  );

  assign eoc_lvl  = sync_bundle[BUNDLE_W-1];
  assign strb_lvl = sync_bundle[DIGIT_W+2:DIGIT_W];
  assign digit_s  = sync_bundle[DIGIT_W-1:0];

  bdc_eoc_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk(clk), .rst_n(rst_n), .eoc_lvl(eoc_lvl),
    .eoc_rise(eoc_rise), .eoc_flag(eoc_seen)
  );

  bdc_strobe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .eoc_rise(eoc_rise), .strb_lvl(strb_lvl),
    .digit(digit_s), .commit(commit), .commit_word(commit_word)
  );

  bdc_result_port u_port (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_word(commit_word),
    .rd_port(rd_port), .rd_strobe(rd_strobe), .result_valid(result_valid),
    .rd_data(rd_data), .half_digit(half_digit), .positive(positive),
    .over_range(over_range), .under_range(under_range), .magnitude(magnitude)
  );
endmodule

// File: tb/bdc_capture_tb_top.sv
module bdc_capture_tb_top;
  localparam int STRETCH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eoc_in = 1'b0;
  logic [3:0] digit_in = '0;
  logic ds_msd_in = 1'b0, ds_shared_in = 1'b0, ds_mid_in = 1'b0;
  logic rd_port = 1'b0, rd_strobe = 1'b0;
  logic eoc_seen, result_valid, half_digit, positive, over_range, under_range;
  logic [7:0] rd_data;
  logic [10:0] magnitude;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bdc_capture #(.SYNC_STAGES(2), .STRETCH_CYCLES(STRETCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .eoc_in(eoc_in), .digit_in(digit_in),
    .ds_msd_in(ds_msd_in), .ds_shared_in(ds_shared_in), .ds_mid_in(ds_mid_in),
    .rd_port(rd_port), .rd_strobe(rd_strobe), .eoc_seen(eoc_seen),
    .result_valid(result_valid), .rd_data(rd_data), .half_digit(half_digit),
    .positive(positive), .over_range(over_range), .under_range(under_range),
    .magnitude(magnitude)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_eoc(input int len);
    @(negedge clk); eoc_in = 1'b1;
    repeat (len) @(negedge clk);
    eoc_in = 1'b0;
    idle(3);
  endtask

  // line: 0 = msd, 1 = shared, 2 = mid
  task automatic strobe(input int line, input logic [3:0] d);
    @(negedge clk); digit_in = d;
    @(negedge clk);
    case (line)
      0: ds_msd_in = 1'b1;
      1: ds_shared_in = 1'b1;
      default: ds_mid_in = 1'b1;
    endcase
    idle(3);
    ds_msd_in = 1'b0; ds_shared_in = 1'b0; ds_mid_in = 1'b0;
    idle(2);
    digit_in = 4'hF;
    idle(2);
  endtask

  task automatic full_seq(input logic [3:0] m, h, t, u);
    strobe(0, m); strobe(1, h); strobe(2, t); strobe(1, u);
    idle(4);
  endtask

  function automatic int exp_mag(input logic [3:0] m, h, t, u);
    return (m[3] ? 1000 : 0) + int'(h) * 100 + int'(t) * 10 + int'(u);
  endfunction

  task automatic read_word(output logic [15:0] w);
    @(negedge clk); rd_port = 1'b1; #1 w[15:8] = rd_data;
    rd_port = 1'b0; #1 w[7:0] = rd_data;
  endtask

  task automatic read_hi_ack();
    @(negedge clk); rd_port = 1'b1; rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0; rd_port = 1'b0;
  endtask

  task automatic expect_result(input string req, input logic [3:0] m, h, t, u);
    logic [15:0] w;
    read_word(w);
    check(req, "word", int'(w), int'({m, h, t, u}));
    check("R9", "magnitude", int'(magnitude), exp_mag(m, h, t, u));
    check("R6", "valid after fourth digit", int'(result_valid), 1);
  endtask

  task automatic t_reset();
    logic [15:0] w;
    check("R1", "eoc_seen", int'(eoc_seen), 0);
    check("R1", "valid", int'(result_valid), 0);
    read_word(w);
    check("R1", "rd_data both bytes", int'(w), 0);
    check("R1", "decodes", int'({half_digit, positive, over_range, under_range}), 0);
    check("R1", "magnitude", int'(magnitude), 0);
  endtask

  task automatic t_no_eoc();
    logic [15:0] w;
    full_seq(4'h4, 4'h1, 4'h2, 4'h3);
    read_word(w);
    check("R4", "word without eoc", int'(w), 0);
    check("R4", "valid without eoc", int'(result_valid), 0);
  endtask

  task automatic t_stretch();
    int width;
    width = 0;
    @(negedge clk); eoc_in = 1'b1;
    @(negedge clk); eoc_in = 1'b0;
    for (int i = 0; i < 3 * STRETCH; i++) begin
      @(negedge clk); if (eoc_seen) width++;
    end
    check("R2", "stretch of 1-cycle pulse", width, STRETCH);
    width = 0;
    @(negedge clk); eoc_in = 1'b1;
    repeat (10) @(negedge clk);
    eoc_in = 1'b0;
    width = 0;
    for (int i = 0; i < 3 * STRETCH; i++) begin
      @(negedge clk); if (eoc_seen) width++;
    end
    // the flag may already be high during the 10 driving cycles minus sync delay
    check("R2", "stretch of 10-cycle pulse (tail)", width, 10 + STRETCH - 1 - 8);
  endtask

  task automatic t_basic();
    pulse_eoc(1);
    full_seq(4'b1100, 4'd9, 4'd8, 4'd7);
    expect_result("R3", 4'b1100, 4'd9, 4'd8, 4'd7);
    check("R8", "half", int'(half_digit), 1);
    check("R8", "positive", int'(positive), 1);
    check("R8", "over/under", int'({over_range, under_range}), 0);
  endtask

  task automatic t_read();
    logic [15:0] w;
    @(negedge clk); rd_port = 1'b1; #1;
    check("R7", "high byte", int'(rd_data), 8'hC9);
    rd_port = 1'b0; #1;
    check("R7", "low byte", int'(rd_data), 8'h87);
    rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    check("R6", "valid after low read", int'(result_valid), 1);
    read_hi_ack();
    check("R6", "valid after high read", int'(result_valid), 0);
    read_word(w);
    check("R6", "word kept after read", int'(w), 16'hC987);
  endtask

  task automatic t_decode();
    pulse_eoc(1);
    full_seq(4'b1010, 4'd9, 4'd9, 4'd9);
    expect_result("R3", 4'b1010, 4'd9, 4'd9, 4'd9);
    check("R8", "half", int'(half_digit), 1);
    check("R8", "negative", int'(positive), 0);
    check("R8", "overrange", int'(over_range), 1);
    check("R8", "underrange", int'(under_range), 0);
    read_hi_ack();
  endtask

  task automatic t_order();
    pulse_eoc(1);
    strobe(2, 4'd5);
    strobe(0, 4'b0100);
    strobe(0, 4'b1111);
    strobe(2, 4'd6);
    strobe(1, 4'd3);
    strobe(0, 4'b0001);
    strobe(2, 4'd2);
    strobe(1, 4'd1);
    idle(4);
    expect_result("R4", 4'b0100, 4'd3, 4'd2, 4'd1);
    check("R8", "positive", int'(positive), 1);
    read_hi_ack();
  endtask

  task automatic t_restart();
    logic [15:0] w;
    pulse_eoc(1);
    strobe(0, 4'b0001);
    strobe(1, 4'd6);
    read_word(w);
    check("R5", "word unchanged mid-sequence", int'(w), 16'h4321);
    check("R5", "valid unchanged mid-sequence", int'(result_valid), 0);
    pulse_eoc(1);
    strobe(1, 4'd7);
    read_word(w);
    check("R5", "shared strobe after restart ignored", int'(w), 16'h4321);
    full_seq(4'b0101, 4'd0, 4'd5, 4'd9);
    expect_result("R5", 4'b0101, 4'd0, 4'd5, 4'd9);
    check("R8", "underrange", int'(under_range), 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_no_eoc();
    t_stretch();
    t_basic();
    t_read();
    t_decode();
    t_order();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule